// File: doc/BRIEF.md
# Dual-Domain Synchronous Clock Prescaler

One main clock is split into two synchronous rate domains: a CPU domain and a backup domain. A free-running 8-bit prescaler counter is shared by both domains. From it, the block derives one clock-enable pulse per domain, so every downstream register stays on the main clock and no derived clock is ever created. Each domain has a stored division setting, loaded through a small register write port. The setting is an exponent: the domain's enable fires once every 2^exponent main-clock cycles.

Every write is checked before it is used. A setting that is out of range, or that would make the CPU domain slower than the backup domain, is still stored and shows on the read-back output. It is never applied, and the block raises a one-cycle violation pulse. A legal setting is not applied at once. It waits for a counter position where the old and the new enable both fire, so no shortened enable period can appear. While any change is waiting, the ready flag is low.

The write port is a valid/ready sink whose ready is always high. A write is taken in every cycle in which `wr_valid` is high, so the producer never sees back-pressure and never has to hold a beat.

Top module: `dual_clk_prescaler`

## Requirements
- R1: After reset both read-back values are 0, `ready` is high, `violation` is low, and both enables are high in every cycle (divide-by-1).
- R2: With an applied exponent e (0 to 7), a domain's enable is high for exactly 256 / 2^e cycles in any 256 consecutive cycles. It fires when the low e bits of the counter are all ones. The counter is 0 in the first cycle after reset and increments by one every cycle.
- R3: A write to one domain never changes the enable rate of the other domain.
- R4: A write whose value would give the CPU domain a larger exponent than the backup domain's last legal setting is forbidden. For a CPU write, the value must be at most the backup setting. For a backup write, the value must be at least the CPU setting.
- R5: A written value above 7 is forbidden.
- R6: A forbidden write is stored for read-back but leaves the domain's rate and the ready flag unchanged. `violation` is high for exactly the one cycle after the write.
- R7: After a legal write, `ready` is low from the next cycle on. The new rate is applied at a counter position where the low max(old,new) bits are all ones. `ready` rises in the cycle after that switch, within 2^max(old,new)+1 cycles of the write. No enable gap during the switch is shorter than the smaller of the two periods.
- R8: A legal write that arrives while an earlier change to the same domain is still pending replaces it. `ready` stays low until the latest value is applied, and the final rate follows that latest value.
- R9: `wr_ready` is always high. `wr_sel` = 0 addresses the CPU domain and 1 the backup domain. The read-back of the addressed domain shows the written byte from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_sel | input | 1 | Target domain: 0 CPU, 1 backup |
| wr_data | input | 8 | Division exponent to write |
| cpu_en | output | 1 | CPU-domain clock enable |
| bup_en | output | 1 | Backup-domain clock enable |
| ready | output | 1 | High when no division change is pending |
| violation | output | 1 | One-cycle pulse after a forbidden write |
| cpu_div_rd | output | 8 | Stored CPU division value |
| bup_div_rd | output | 8 | Stored backup division value |

## Verification
The hardest case to reach from the ports is the replacement of a pending change. The second write has to land before the first one reaches its switch point, and that depends on the hidden counter phase. The bench sets the backup exponent to 7, so its enable marks the cycle in which the low seven counter bits are all ones. It then issues two CPU writes back to back right at that pulse, which puts the next switch point about 64 cycles away. This makes the pending state certain rather than a matter of luck. The same run measures every CPU enable gap across the switch, to catch a runt period.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

  typedef enum logic {
    DOM_CPU = 1'b0,
    DOM_BUP = 1'b1
  } dom_e;

  localparam int unsigned NUM_DOM = 2;

endpackage

// File: rtl/clkpre_counter.sv
module clkpre_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // counter advances by one every cycle (supports R2 phase rule)
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/clkpre_legal.sv
module clkpre_legal
  import clkpre_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned EXP_W = 3
) (
  input  logic             wr_valid,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [EXP_W-1:0] tgt_cpu,
  input  logic [EXP_W-1:0] tgt_bup,
  output logic             ok_cpu,
  output logic             ok_bup,
  output logic             bad
);

  localparam int unsigned MAX_EXP = (1 << EXP_W) - 1;

  logic             in_range;
  logic [EXP_W-1:0] val;
  logic             order_ok;

  always_comb begin
    in_range = (wr_data <= REG_W'(MAX_EXP));
    val      = wr_data[EXP_W-1:0];
    if (wr_sel == DOM_CPU) order_ok = (val <= tgt_bup);
    else                   order_ok = (val >= tgt_cpu);
    ok_cpu = wr_valid && (wr_sel == DOM_CPU) && in_range && order_ok;
    ok_bup = wr_valid && (wr_sel == DOM_BUP) && in_range && order_ok;
    bad    = wr_valid && !(in_range && order_ok);
  end

endmodule

// File: rtl/clkpre_domain.sv
module clkpre_domain #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REG_W = 8,
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_stb,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_val,
  output logic [EXP_W-1:0] tgt,
  output logic             pend,
  output logic             en
);

  logic [EXP_W-1:0] act;
  logic [EXP_W-1:0] emax;
  logic [CNT_W-1:0] mask_act;
  logic [CNT_W-1:0] mask_max;
  logic             at_bnd;

  always_comb begin
    mask_act = CNT_W'((1 << act) - 1);
    emax     = (tgt > act) ? tgt : act;
    mask_max = CNT_W'((1 << emax) - 1);
    en       = ((cnt & mask_act) == mask_act);
    at_bnd   = ((cnt & mask_max) == mask_max);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_val <= '0;
      tgt    <= '0;
      act    <= '0;
      pend   <= 1'b0;
    end else begin
      if (wr_stb) rd_val <= wr_data;
      if (wr_ok) begin
        tgt  <= wr_data[EXP_W-1:0];
        pend <= 1'b1;
      end else if (pend && at_bnd) begin
        act  <= tgt;
        pend <= 1'b0;
      end
    end
  end

  // a rate switch only happens in a cycle where the old enable fired
  p_switch_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(act) |-> $past(en));

  // the applied rate only moves while a change is pending
  p_switch_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(act) |-> $past(pend));

endmodule

// File: rtl/dual_clk_prescaler.sv
module dual_clk_prescaler
  import clkpre_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             cpu_en,
  output logic             bup_en,
  output logic             ready,
  output logic             violation,
  output logic [REG_W-1:0] cpu_div_rd,
  output logic [REG_W-1:0] bup_div_rd
);

  localparam int unsigned EXP_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt;
  logic [EXP_W-1:0] tgt  [NUM_DOM];
  logic [REG_W-1:0] rdv  [NUM_DOM];
  logic             pend [NUM_DOM];
  logic             en   [NUM_DOM];
  logic             ok   [NUM_DOM];
  logic             bad;
  logic             viol_q;

  assign wr_ready = 1'b1;

  clkpre_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt)
  );

  clkpre_legal #(.REG_W(REG_W), .EXP_W(EXP_W)) u_legal (
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tgt_cpu  (tgt[DOM_CPU]),
    .tgt_bup  (tgt[DOM_BUP]),
    .ok_cpu   (ok[DOM_CPU]),
    .ok_bup   (ok[DOM_BUP]),
    .bad      (bad)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic stb;
    assign stb = wr_valid && (wr_sel == 1'(d));
    clkpre_domain #(.CNT_W(CNT_W), .REG_W(REG_W), .EXP_W(EXP_W)) u_dom (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .wr_stb  (stb),
      .wr_ok   (ok[d]),
      .wr_data (wr_data),
      .rd_val  (rdv[d]),
      .tgt     (tgt[d]),
      .pend    (pend[d]),
      .en      (en[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= bad;
  end

  assign cpu_en     = en[DOM_CPU];
  assign bup_en     = en[DOM_BUP];
  assign cpu_div_rd = rdv[DOM_CPU];
  assign bup_div_rd = rdv[DOM_BUP];
  assign ready      = !(pend[DOM_CPU] || pend[DOM_BUP]);
  assign violation  = viol_q;

  // legal targets keep the CPU domain at least as fast as backup
  p_rate_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt[DOM_CPU] <= tgt[DOM_BUP]);

  // a violation is always caused by a write beat one cycle earlier
  p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && violation |-> $past(wr_valid));

  // a forbidden write leaves both legal targets untouched
  p_hold_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && violation |-> $stable(tgt[DOM_CPU]) && $stable(tgt[DOM_BUP]));

  // write port never applies back-pressure
  p_always_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

endmodule

// File: tb/test_dual_clk_prescaler.sv
module test_dual_clk_prescaler;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cpu_en, bup_en, ready, violation;
  logic [7:0] cpu_div_rd, bup_div_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clk_prescaler i_dual_clk_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cpu_en     (cpu_en),
    .bup_en     (bup_en),
    .ready      (ready),
    .violation  (violation),
    .cpu_div_rd (cpu_div_rd),
    .bup_div_rd (bup_div_rd)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] data);
    wr_valid = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic measure(input int exp_cpu, input int exp_bup, input string req);
    int nc = 0;
    int nb = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (cpu_en) nc++;
      if (bup_en) nb++;
    end
    check(nc == (256 >> exp_cpu), {req, " cpu rate"}, nc, 256 >> exp_cpu);
    check(nb == (256 >> exp_bup), {req, " bup rate"}, nb, 256 >> exp_bup);
  endtask

  task automatic wait_switch(input int limit, input int min_gap, input string req);
    int last = -1;
    int mgap = 1000;
    int rise = -1;
    for (int i = 0; i < 300; i++) begin
      if (cpu_en) begin
        if (last >= 0 && (i - last) < mgap) mgap = i - last;
        last = i;
      end
      if (ready && rise < 0) rise = i;
      @(negedge clk);
    end
    check(rise >= 1 && rise <= limit, {req, " ready rise cycle"}, rise, limit);
    check(mgap >= min_gap, {req, " cpu min gap"}, mgap, min_gap);
  endtask

  task automatic t_reset;
    check(cpu_div_rd == 0 && bup_div_rd == 0, "R1 readback", cpu_div_rd, 0);
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(violation == 1'b0, "R1 violation", violation, 0);
    for (int i = 0; i < 4; i++) begin
      check(cpu_en && bup_en, "R1 enables every cycle", {cpu_en, bup_en}, 3);
      @(negedge clk);
    end
    check(wr_ready == 1'b1, "R9 wr_ready", wr_ready, 1);
  endtask

  task automatic t_bup_legal;
    do_write(1'b1, 8'd3);
    check(bup_div_rd == 3, "R9 bup readback", bup_div_rd, 3);
    check(ready == 1'b0, "R7 ready low", ready, 0);
    check(violation == 1'b0, "R6 no violation on legal", violation, 0);
    wait_switch(9, 1, "R7 bup 0->3");
    measure(0, 3, "R2 R3 bup=3");
  endtask

  task automatic t_cpu_legal;
    do_write(1'b0, 8'd2);
    check(cpu_div_rd == 2, "R9 cpu readback", cpu_div_rd, 2);
    check(ready == 1'b0, "R7 ready low", ready, 0);
    wait_switch(5, 1, "R7 cpu 0->2");
    measure(2, 3, "R2 R3 cpu=2");
  endtask

  task automatic t_cpu_slower;
    do_write(1'b0, 8'd5);
    check(violation == 1'b1, "R4 violation cpu>bup", violation, 1);
    check(cpu_div_rd == 5, "R6 stored forbidden", cpu_div_rd, 5);
    check(ready == 1'b1, "R6 ready unchanged", ready, 1);
    @(negedge clk);
    check(violation == 1'b0, "R6 one-cycle pulse", violation, 0);
    measure(2, 3, "R6 rate kept");
  endtask

  task automatic t_out_of_range;
    do_write(1'b1, 8'd9);
    check(violation == 1'b1, "R5 violation >7", violation, 1);
    check(bup_div_rd == 9, "R5 stored", bup_div_rd, 9);
    @(negedge clk);
    check(violation == 1'b0, "R5 pulse ends", violation, 0);
    measure(2, 3, "R5 rate kept");
  endtask

  task automatic t_bup_faster;
    do_write(1'b1, 8'd1);
    check(violation == 1'b1, "R4 violation bup<cpu", violation, 1);
    check(ready == 1'b1, "R4 ready unchanged", ready, 1);
    measure(2, 3, "R4 rate kept");
  endtask

  task automatic t_replace;
    do_write(1'b1, 8'd7);
    wait_switch(129, 1, "R7 bup 3->7");
    measure(2, 7, "R2 bup=7");
    while (!bup_en) @(negedge clk);
    do_write(1'b0, 8'd6);
    do_write(1'b0, 8'd4);
    check(ready == 1'b0, "R8 ready low while replaced", ready, 0);
    check(cpu_div_rd == 4, "R8 readback latest", cpu_div_rd, 4);
    check(violation == 1'b0, "R8 no violation", violation, 0);
    wait_switch(20, 4, "R8 R7 cpu 2->4");
    measure(4, 7, "R8 final rate");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bup_legal();
    t_cpu_legal();
    t_cpu_slower();
    t_out_of_range();
    t_bup_faster();
    t_replace();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule